// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block merges the three interrupt causes of a real-time clock into a single active-low interrupt line. The causes are alarm match, periodic tick and end of a time update. Each cause arrives as a one-cycle strobe from logic outside the block. A strobe sets a sticky flag, and it does so whatever the enable setting. The flags are then masked by a software-owned enable register. The interrupt line goes low while any cause is both flagged and enabled.

Software reaches two registers over a simple synchronous bus. Read strobes and write strobes each last one cycle, and read data is valid combinationally during the strobe cycle. The flag register is read-only, and reading it clears it. Its top bit reports whether the interrupt line is currently driven low.

Some events land in the same cycle as a flag read. Such an event is kept out of the returned value so that the value is stable. It goes into a pending latch and merges into the flags one cycle after the clear.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every flag, enable and pending bit is 0, irqN is 1, and both registers read 0x00.
- R2: A strobe on evAlarm, evPeriodic or evUpdate in a cycle with no flag read sets that cause's flag at the next edge, regardless of its enable. A flag stays set until the flag register is read.
- R3: A write with busAddr=0 loads the enable register. Bit 6 enables periodic, bit 5 enables alarm and bit 4 enables update-ended. The other bits read back as 0.
- R4: irqN is 0 exactly when some cause has both its flag and its enable set, and is 1 otherwise.
- R5: Enabling a cause whose flag is already set drives irqN low in the cycle right after the write.
- R6: A read with busAddr=1 returns the flags at bit 6 (periodic), bit 5 (alarm) and bit 4 (update-ended), with bits 3..0 reading 0. Every flag is clear from the next cycle on.
- R7: An event that arrives in the cycle of a flag read is absent from that read's data. It shows in the flags two cycles after the read cycle.
- R8: Bit 7 of the flag register reads 1 exactly when irqN is 0.
- R9: Writes with busAddr=1 change neither the flags nor irqN.
- R10: Reading the enable register leaves the flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evAlarm | input | 1 | One-cycle alarm event strobe |
| evPeriodic | input | 1 | One-cycle periodic event strobe |
| evUpdate | input | 1 | One-cycle update-ended event strobe |
| busAddr | input | 1 | Register select: 0 enable, 1 flags |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid during the read strobe |
| irqN | output | 1 | Active-low interrupt line |

## Verification
A flag read and a new event can fall in the same cycle, and the two must not be merged. The bench drives a periodic strobe together with a flag read strobe. It expects the read data to lack that cause. It expects irqN to stay high in the following cycle. It expects the flag and a low irqN one cycle later, and a second read to return it. All 64 enable/event combinations are swept, and the irqN level and read data are each compared against the masked-OR formula worked out in the bench.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_SRC  = 3;
  localparam int SRC_LSB  = 4;
  localparam int BIT_SUM  = 7;
  localparam logic ADDR_EN   = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  typedef struct packed {
    logic clrFlags;
    logic holdEvents;
    logic wrEnable;
    logic selFlag;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtc_irq_ctrl_dec.sv
module rtc_irq_ctrl_dec
  import rtc_irq_pkg::*;
(
  input  logic        busAddr,
  input  logic        busWr,
  input  logic        busRd,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.selFlag    = (busAddr == ADDR_FLAG);
    strobe.clrFlags   = busRd && (busAddr == ADDR_FLAG);
    strobe.holdEvents = busRd && (busAddr == ADDR_FLAG);
    strobe.wrEnable   = busWr && (busAddr == ADDR_EN);
  end
endmodule

// File: rtl/rtc_irq_datapath.sv
module rtc_irq_datapath
  import rtc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] events,
  input  logic [DATA_W-1:0]  wdata,
  input  ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqN
);
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] enables;
  logic               active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      pend    <= '0;
      enables <= '0;
    end else begin
      if (strobe.wrEnable) enables <= wdata[SRC_LSB +: NUM_SRC];
      if (strobe.clrFlags) begin
        flags <= '0;
        pend  <= (strobe.holdEvents) ? (pend | events) : pend;
      end else begin
        flags <= flags | pend | events;
        pend  <= '0;
      end
    end
  end

  assign active = |(flags & enables);
  assign irqN   = ~active;

  always_comb begin
    rdata = '0;
    if (strobe.selFlag) begin
      rdata[BIT_SUM]               = active;
      rdata[SRC_LSB +: NUM_SRC]    = flags;
    end else begin
      rdata[SRC_LSB +: NUM_SRC]    = enables;
    end
  end

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFlags |=> (flags == '0)); // R6
  AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFlags && (events != '0)) |=> ((pend & $past(events)) == $past(events))); // R7
  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrFlags |=> ((flags & $past(flags | events)) == $past(flags | events))); // R2
  AST_ENABLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEnable |=> $stable(enables)); // R3
  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0) |-> irqN); // R4
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evAlarm,
  input  logic              evPeriodic,
  input  logic              evUpdate,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqN
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] events;

  assign events = {evPeriodic, evAlarm, evUpdate};

  rtc_irq_ctrl_dec ctrl_i (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobe  (strobe)
  );

  rtc_irq_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .events (events),
    .wdata  (busWdata),
    .strobe (strobe),
    .rdata  (busRdata),
    .irqN   (irqN)
  );

  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_FLAG) |-> (busRdata[BIT_SUM] == !irqN)); // R8
  AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_FLAG && !busRd && !evAlarm && !evPeriodic && !evUpdate) |=> $stable(irqN)); // R9
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evAlarm = 0, evPeriodic = 0, evUpdate = 0;
  logic busAddr = 0, busWr = 0, busRd = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic irqN;
  int nChk = 0, nErr = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  rtc_irq_ctrl dut_i (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic addr, output logic [7:0] data);
    @(negedge clk); busAddr = addr; busRd = 1; #1 data = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  task automatic doWrite(input logic addr, input logic [7:0] d);
    @(negedge clk); busAddr = addr; busWr = 1; busWdata = d;
    @(negedge clk); busWr = 0;
  endtask

  task automatic pulse(input logic [2:0] f);
    @(negedge clk); {evPeriodic, evAlarm, evUpdate} = f;
    @(negedge clk); {evPeriodic, evAlarm, evUpdate} = 3'b000;
  endtask

  function automatic logic [7:0] expFlagRd(input logic [2:0] f, input logic [2:0] e);
    return {|(f & e), f, 4'b0000};
  endfunction

  initial begin
    #2_000_000;
    nErr++;
    $display("FAIL watchdog expired actual=01 expected=00");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1 check("R1 irqN", {7'b0, irqN}, 8'h01);
    doRead(1'b0, rd); check("R1 enable reg", rd, 8'h00);
    doRead(1'b1, rd); check("R1 flag reg", rd, 8'h00);

    for (int e = 0; e < 8; e++) begin
      doWrite(1'b0, {1'b0, e[2:0], 4'hF} | 8'h80);
      doRead(1'b0, rd); check("R3 enable readback", rd, {1'b0, e[2:0], 4'h0});
      for (int f = 0; f < 8; f++) begin
        pulse(f[2:0]);
        #1 check("R4 irqN level", {7'b0, irqN}, {7'b0, ~|(f[2:0] & e[2:0])});
        doRead(1'b1, rd); check("R6 R8 flag read", rd, expFlagRd(f[2:0], e[2:0]));
        #1 check("R6 irqN after clear", {7'b0, irqN}, 8'h01);
        doRead(1'b1, rd); check("R6 flags cleared", rd, 8'h00);
      end
    end

    doWrite(1'b0, 8'h00);
    pulse(3'b010);
    #1 check("R2 flag set while disabled irqN", {7'b0, irqN}, 8'h01);
    doWrite(1'b0, 8'h20);
    #1 check("R5 late enable asserts irqN", {7'b0, irqN}, 8'h00);
    doWrite(1'b1, 8'h00);
    #1 check("R9 irqN unchanged by flag write", {7'b0, irqN}, 8'h00);
    doRead(1'b0, rd); check("R10 enable read", rd, 8'h20);
    doRead(1'b1, rd); check("R9 R10 flags kept", rd, 8'hA0);
    doWrite(1'b1, 8'hF0);
    #1 check("R9 write cannot set irq", {7'b0, irqN}, 8'h01);
    doRead(1'b1, rd); check("R9 write cannot set flags", rd, 8'h00);

    doWrite(1'b0, 8'h70);
    pulse(3'b001);
    @(negedge clk); busAddr = 1; busRd = 1; evPeriodic = 1; #1 rd = busRdata;
    check("R7 read excludes same-cycle event", rd, 8'h90);
    @(negedge clk); busRd = 0; evPeriodic = 0;
    #1 check("R7 irqN high after read", {7'b0, irqN}, 8'h01);
    @(negedge clk);
    #1 check("R7 held event merged", {7'b0, irqN}, 8'h00);
    doRead(1'b1, rd); check("R7 held event read", rd, 8'hC0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule